// File: doc/BRIEF.md
# Operand Register File with Early Synchronous Read and Write Forwarding

This block holds the architected operand registers of an in-order core: 64 entries of 64 bits. The lower half holds the integer registers and the upper half the floating-point registers, so the top address bit picks the bank. It has three read ports (A, B and C) and one write port. The early decode stage sends all three operand addresses one cycle before the operands are needed. These addresses are always present, whether the instruction uses them or not. The storage is read synchronously, so it can map onto block RAM.

The file captures its read addresses at every clock edge. While the pipeline is stalled it reads again from the captured addresses and ignores new ones. The write port is also captured. A compare on each read port returns the captured write data when its read address matches the captured write address. A debugger may read or write any entry through the B port, but only in a cycle when the pipeline does not need that port. A debug request stays pending until that happens. Read data comes back one cycle after acceptance, together with a valid strobe.

Top module: `opnd_regfile`

## Requirements
- R1: The file has 64 entries of 64 bits. Addresses 0–31 are integer registers and 32–63 are floating-point registers. Entry n and entry n+32 are distinct storage.
- R2: When stall is low, an address presented on a read port in cycle N returns that entry's data on the same port's data output in cycle N+1. The three ports work independently.
- R3: When stall is high in cycle N, the addresses captured in cycle N-1 are read again and the addresses presented in cycle N are ignored.
- R4: A write presented in cycle N (wr_en high) is visible in cycle N+1 on every read port whose effective address in cycle N equals the write address. This includes a port reading its held address during a stall. The write is also visible in every later read.
- R5: A write cycle with wr_en low changes no entry.
- R6: dbg_ack is high only while dbg_req is high and the B port is free. The B port is free when the instruction is not valid or does not use a B operand. During a stall, the B-port need of the held instruction applies.
- R7: A debug request that is not acknowledged is not lost. It is accepted in the first later cycle that meets the conditions, as long as dbg_req stays high.
- R8: After an accepted debug read (dbg_we low) in cycle N, dbg_rvalid is high in cycle N+1 and dbg_rdata holds the entry, including forwarding of a pipeline write from cycle N. dbg_rvalid is low after any other cycle.
- R9: A debug write (dbg_we high) is accepted only in a cycle with wr_en low. It then stores dbg_wdata at dbg_addr. Debug reads are not held back by pipeline writes.
- R10: After synchronous active-low reset, the three read data outputs are zero, and dbg_rvalid and dbg_ack are low with no request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Pipeline stall; reuse previous read addresses |
| insn_valid | input | 1 | Early-decode instruction is valid |
| insn_uses_b | input | 1 | That instruction uses a B operand |
| rd_a_addr | input | 6 | Early read address, port A |
| rd_b_addr | input | 6 | Early read address, port B |
| rd_c_addr | input | 6 | Early read address, port C |
| rd_a_data | output | 64 | Read data, port A (one cycle after address) |
| rd_b_data | output | 64 | Read data, port B |
| rd_c_data | output | 64 | Read data, port C |
| wr_en | input | 1 | Pipeline write enable |
| wr_addr | input | 6 | Pipeline write address |
| wr_data | input | 64 | Pipeline write data |
| dbg_req | input | 1 | Debug access request |
| dbg_we | input | 1 | Debug access is a write |
| dbg_addr | input | 6 | Debug entry address |
| dbg_wdata | input | 64 | Debug write data |
| dbg_ack | output | 1 | Debug request accepted this cycle |
| dbg_rvalid | output | 1 | Debug read data valid |
| dbg_rdata | output | 64 | Debug read data |

## Verification
Read data and debug read data are registered, so the result is due exactly one clock edge after the cycle in which the address, stall, write or accepted request is presented. dbg_ack is combinational and is due in the same cycle. The bench drives each stimulus on the falling edge. It samples dbg_ack one nanosecond later, in the same cycle, and samples read data, dbg_rvalid and dbg_rdata on the next falling edge, after the single register stage. Forwarding cases present the write and the matching read in the same cycle, so each forwarding check lands on the cycle where the latched write and the registered RAM output meet.

// File: rtl/rf_pkg.sv
// Shared constants and types for the operand register file.
// Assumes three read ports, with port B as the one shared with debug access.
package rf_pkg;
    localparam int unsigned RD_PORTS = 3;
    localparam int unsigned PORT_A   = 0;
    localparam int unsigned PORT_B   = 1;
    localparam int unsigned PORT_C   = 2;

    // Which requester drives the B read port address this cycle
    typedef enum logic {
        B_PIPE  = 1'b0,
        B_DEBUG = 1'b1
    } bsrc_e;
endpackage

// File: rtl/rf_addr_stage.sv
// Read-address selection and B-port arbitration.
// Captures the early read addresses every cycle and reuses them while stalled.
// Grants a debug request only when the B port is free. Debug writes also wait
// for the shared write port to be idle.
// Assumes insn_valid/insn_uses_b arrive together with the early addresses.
module rf_addr_stage
    import rf_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic [ADDR_W-1:0] early_addr [RD_PORTS],
    input  logic              insn_valid,
    input  logic              insn_uses_b,
    input  logic              dbg_req,
    input  logic              dbg_we,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic              pipe_wr_en,
    output logic [ADDR_W-1:0] ram_addr [RD_PORTS],
    output logic              dbg_grant
);
    logic [ADDR_W-1:0] held_q    [RD_PORTS];
    logic [ADDR_W-1:0] pipe_addr [RD_PORTS];
    logic              b_need;
    logic              b_need_q;
    bsrc_e             b_src;

    // B-port need follows the held instruction while stalled
    always_comb begin
        b_need = stall ? b_need_q : (insn_valid & insn_uses_b);
    end

    // Grant debug on a free B port; a debug write also needs the write port idle
    always_comb begin
        dbg_grant = dbg_req & ~b_need & (~dbg_we | ~pipe_wr_en);
        b_src     = (dbg_grant & ~dbg_we) ? B_DEBUG : B_PIPE;
    end

    // Keep the B-port need of the current instruction for stalled cycles
    always_ff @(posedge clk) begin
        if (!rst_n) b_need_q <= 1'b0;
        else        b_need_q <= b_need;
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
        // Pipeline address: captured copy while stalled, early address otherwise
        always_comb begin
            pipe_addr[p] = stall ? held_q[p] : early_addr[p];
        end

        // Capture this cycle's pipeline address for reuse on a stall
        always_ff @(posedge clk) begin
            if (!rst_n) held_q[p] <= '0;
            else        held_q[p] <= pipe_addr[p];
        end

        if (p == PORT_B) begin : g_shared
            // The shared port takes the debug address on a granted debug read
            always_comb begin
                ram_addr[p] = (b_src == B_DEBUG) ? dbg_addr : pipe_addr[p];
            end
        end else begin : g_plain
            // The other ports always read the pipeline address
            always_comb begin
                ram_addr[p] = pipe_addr[p];
            end
        end
    end
endmodule

// File: rtl/rf_array.sv
// Storage array with one write port and RD_PORTS registered read ports.
// Reads return the contents from before a same-edge write (read-before-write);
// forwarding is handled downstream. The storage itself is not reset, only the
// read output registers are.
module rf_array
    import rf_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr [RD_PORTS],
    output logic [DATA_W-1:0] rdata_q [RD_PORTS]
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Single synchronous write port
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        // Registered read of one port
        always_ff @(posedge clk) begin
            if (!rst_n) rdata_q[p] <= '0;
            else        rdata_q[p] <= mem[raddr[p]];
        end
    end
endmodule

// File: rtl/rf_bypass.sv
// Per-port write forwarding. Captures the write that goes with the read edge
// and, on each port whose captured read address matches, replaces the stale
// registered RAM data with the captured write data.
module rf_bypass
    import rf_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr [RD_PORTS],
    input  logic [DATA_W-1:0] ram_q [RD_PORTS],
    output logic [DATA_W-1:0] rd_out [RD_PORTS]
);
    logic              we_q;
    logic [ADDR_W-1:0] waddr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [ADDR_W-1:0] raddr_q [RD_PORTS];

    // Capture the write that goes with this read edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            waddr_q <= '0;
            wdata_q <= '0;
        end else begin
            we_q    <= we;
            waddr_q <= waddr;
            wdata_q <= wdata;
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_fwd
        // Capture the address this port actually read
        always_ff @(posedge clk) begin
            if (!rst_n) raddr_q[p] <= '0;
            else        raddr_q[p] <= raddr[p];
        end

        // Return forwarded write data on a match, else the RAM output
        always_comb begin
            rd_out[p] = (we_q && (waddr_q == raddr_q[p])) ? wdata_q : ram_q[p];
        end
    end
endmodule

// File: rtl/opnd_regfile.sv
// Operand register file: 64 x 64-bit, integer bank low, floating-point high.
// Three synchronous read ports fed by early-decode addresses, one pipeline
// write port, write forwarding per port, and debug access that borrows the
// B port in idle cycles. Debug writes share the write port and yield to the
// pipeline.
module opnd_regfile
    import rf_pkg::*;
#(
    parameter  int unsigned NUM_REGS = 64,
    parameter  int unsigned DATA_W   = 64,
    localparam int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              insn_valid,
    input  logic              insn_uses_b,
    input  logic [ADDR_W-1:0] rd_a_addr,
    input  logic [ADDR_W-1:0] rd_b_addr,
    input  logic [ADDR_W-1:0] rd_c_addr,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data,
    output logic [DATA_W-1:0] rd_c_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              dbg_req,
    input  logic              dbg_we,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic              dbg_ack,
    output logic              dbg_rvalid,
    output logic [DATA_W-1:0] dbg_rdata
);
    logic [ADDR_W-1:0] early_addr [RD_PORTS];
    logic [ADDR_W-1:0] ram_addr   [RD_PORTS];
    logic [DATA_W-1:0] ram_q      [RD_PORTS];
    logic [DATA_W-1:0] rd_out     [RD_PORTS];
    logic              grant;
    logic              w_en;
    logic [ADDR_W-1:0] w_addr;
    logic [DATA_W-1:0] w_data;

    // Gather the early addresses into the port array
    always_comb begin
        early_addr[PORT_A] = rd_a_addr;
        early_addr[PORT_B] = rd_b_addr;
        early_addr[PORT_C] = rd_c_addr;
    end

    // Shared write port: the pipeline has priority, a granted debug write fills idle cycles
    always_comb begin
        w_en   = wr_en | (grant & dbg_we);
        w_addr = wr_en ? wr_addr : dbg_addr;
        w_data = wr_en ? wr_data : dbg_wdata;
    end

    rf_addr_stage #(.ADDR_W(ADDR_W)) addr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall       (stall),
        .early_addr  (early_addr),
        .insn_valid  (insn_valid),
        .insn_uses_b (insn_uses_b),
        .dbg_req     (dbg_req),
        .dbg_we      (dbg_we),
        .dbg_addr    (dbg_addr),
        .pipe_wr_en  (wr_en),
        .ram_addr    (ram_addr),
        .dbg_grant   (grant)
    );

    rf_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (w_en),
        .waddr   (w_addr),
        .wdata   (w_data),
        .raddr   (ram_addr),
        .rdata_q (ram_q)
    );

    rf_bypass #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) bypass_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (w_en),
        .waddr  (w_addr),
        .wdata  (w_data),
        .raddr  (ram_addr),
        .ram_q  (ram_q),
        .rd_out (rd_out)
    );

    // Debug read data is valid one edge after a granted read
    always_ff @(posedge clk) begin
        if (!rst_n) dbg_rvalid <= 1'b0;
        else        dbg_rvalid <= grant & ~dbg_we;
    end

    assign dbg_ack   = grant;
    assign rd_a_data = rd_out[PORT_A];
    assign rd_b_data = rd_out[PORT_B];
    assign rd_c_data = rd_out[PORT_C];
    assign dbg_rdata = rd_out[PORT_B];
endmodule

// File: rtl/opnd_regfile_chk.sv
// Protocol and timing checks for opnd_regfile, attached by bind.
module opnd_regfile_chk #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              insn_valid,
    input logic              insn_uses_b,
    input logic [ADDR_W-1:0] rd_a_addr,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [DATA_W-1:0] rd_c_data,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              dbg_req,
    input logic              dbg_we,
    input logic              dbg_ack,
    input logic              dbg_rvalid
);
    logic armed_q;

    // Set once outputs come from a real read rather than from reset
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    a_r6_no_grant_when_b_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && insn_valid && insn_uses_b) |-> !dbg_ack);

    a_r6_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_ack |-> dbg_req);

    a_r9_dbg_write_yields: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_ack && dbg_we) |-> !wr_en);

    a_r8_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_ack && !dbg_we) |=> dbg_rvalid);

    a_r8_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbg_ack && !dbg_we) |=> !dbg_rvalid);

    a_r4_forward_port_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && wr_en && (rd_a_addr == wr_addr)) |=> (rd_a_data == $past(wr_data)));

    a_r3_hold_port_a: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && stall && !wr_en && !dbg_ack) |=> $stable(rd_a_data));

    a_r3_hold_port_c: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && stall && !wr_en && !dbg_ack) |=> $stable(rd_c_data));
endmodule

bind opnd_regfile opnd_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall       (stall),
    .insn_valid  (insn_valid),
    .insn_uses_b (insn_uses_b),
    .rd_a_addr   (rd_a_addr),
    .rd_a_data   (rd_a_data),
    .rd_c_data   (rd_c_data),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .dbg_req     (dbg_req),
    .dbg_we      (dbg_we),
    .dbg_ack     (dbg_ack),
    .dbg_rvalid  (dbg_rvalid)
);

// File: tb/opnd_regfile_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: preload, a vector table walked by one loop, then
// directed reset and debug-port tests.
module opnd_regfile_tb_top;
    localparam logic [63:0] P  = 64'h1111_0000_0000_0000;
    localparam logic [63:0] WA = 64'hAAAA_0000_0000_0005;
    localparam logic [63:0] WB = 64'hBBBB_0000_0000_0006;
    localparam logic [63:0] WF = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] WC = 64'hCCCC_0000_0000_0028;
    localparam logic [63:0] WD = 64'hDDDD_0000_0000_0009;
    localparam logic [63:0] WE = 64'hEEEE_0000_0000_000C;
    localparam logic [63:0] W5 = 64'h5555_0000_0000_000D;
    localparam logic [63:0] W7 = 64'h7777_0000_0000_0014;

    typedef struct packed {
        logic        stall;
        logic [5:0]  a, b, c;
        logic        wen;
        logic [5:0]  waddr;
        logic [63:0] wdata;
        logic [63:0] ea, eb, ec;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 6'd1,  6'd2,  6'd33, 1'b0, 6'd0,  64'd0, P+64'd1,  P+64'd2,  P+64'd33},
        '{1'b0, 6'd0,  6'd32, 6'd63, 1'b0, 6'd0,  64'd0, P+64'd0,  P+64'd32, P+64'd63},
        '{1'b0, 6'd5,  6'd5,  6'd37, 1'b1, 6'd5,  WA,    WA,       WA,       P+64'd37},
        '{1'b0, 6'd5,  6'd6,  6'd5,  1'b0, 6'd0,  64'd0, WA,       P+64'd6,  WA},
        '{1'b1, 6'd10, 6'd11, 6'd12, 1'b0, 6'd0,  64'd0, WA,       P+64'd6,  WA},
        '{1'b1, 6'd20, 6'd20, 6'd20, 1'b1, 6'd6,  WB,    WA,       WB,       WA},
        '{1'b0, 6'd37, 6'd6,  6'd6,  1'b0, 6'd37, WF,    P+64'd37, WB,       WB},
        '{1'b0, 6'd37, 6'd38, 6'd39, 1'b0, 6'd0,  64'd0, P+64'd37, P+64'd38, P+64'd39},
        '{1'b0, 6'd8,  6'd40, 6'd40, 1'b1, 6'd40, WC,    P+64'd8,  WC,       WC},
        '{1'b0, 6'd8,  6'd40, 6'd9,  1'b0, 6'd0,  64'd0, P+64'd8,  WC,       P+64'd9},
        '{1'b0, 6'd1,  6'd2,  6'd3,  1'b1, 6'd9,  WD,    P+64'd1,  P+64'd2,  P+64'd3},
        '{1'b0, 6'd9,  6'd9,  6'd9,  1'b0, 6'd0,  64'd0, WD,       WD,       WD}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        stall, insn_valid, insn_uses_b;
    logic [5:0]  rd_a_addr, rd_b_addr, rd_c_addr;
    logic [63:0] rd_a_data, rd_b_data, rd_c_data;
    logic        wr_en;
    logic [5:0]  wr_addr;
    logic [63:0] wr_data;
    logic        dbg_req, dbg_we;
    logic [5:0]  dbg_addr;
    logic [63:0] dbg_wdata;
    logic        dbg_ack, dbg_rvalid;
    logic [63:0] dbg_rdata;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    opnd_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .stall(stall), .insn_valid(insn_valid),
        .insn_uses_b(insn_uses_b), .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
        .rd_c_addr(rd_c_addr), .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .rd_c_data(rd_c_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
        .dbg_ack(dbg_ack), .dbg_rvalid(dbg_rvalid), .dbg_rdata(dbg_rdata)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string row_req(input int k);
        case (k)
            0:       return "R2";
            1:       return "R1";
            2:       return "R4";
            4:       return "R3";
            5:       return "R3";
            6:       return "R5";
            7:       return "R5";
            8:       return "R1";
            default: return "R4";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; stall = 1'b0; insn_valid = 1'b0; insn_uses_b = 1'b0;
        rd_a_addr = '0; rd_b_addr = '0; rd_c_addr = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        dbg_req = 1'b0; dbg_we = 1'b0; dbg_addr = '0; dbg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        chk("R10", "rd_a_data", rd_a_data, 64'd0);
        chk("R10", "rd_b_data", rd_b_data, 64'd0);
        chk("R10", "rd_c_data", rd_c_data, 64'd0);
        chk("R10", "dbg_rvalid", {63'd0, dbg_rvalid}, 64'd0);
        chk("R10", "dbg_ack", {63'd0, dbg_ack}, 64'd0);

        // Preload every entry with P + index
        @(negedge clk);
        for (int i = 0; i < 64; i++) begin
            wr_en = 1'b1; wr_addr = 6'(i); wr_data = P + 64'(i);
            @(negedge clk);
        end
        wr_en = 1'b0;

        // Vector table: drive row, check one edge later
        insn_valid = 1'b1; insn_uses_b = 1'b1;
        for (int k = 0; k < NV; k++) begin
            stall = VEC[k].stall;
            rd_a_addr = VEC[k].a; rd_b_addr = VEC[k].b; rd_c_addr = VEC[k].c;
            wr_en = VEC[k].wen; wr_addr = VEC[k].waddr; wr_data = VEC[k].wdata;
            @(negedge clk);
            chk(row_req(k), $sformatf("row %0d port A", k), rd_a_data, VEC[k].ea);
            chk(row_req(k), $sformatf("row %0d port B", k), rd_b_data, VEC[k].eb);
            chk(row_req(k), $sformatf("row %0d port C", k), rd_c_data, VEC[k].ec);
        end
        stall = 1'b0; wr_en = 1'b0;

        // R6/R7: debug read blocked while B in use, then accepted
        dbg_req = 1'b1; dbg_we = 1'b0; dbg_addr = 6'd40;
        #1 chk("R6", "ack while B busy", {63'd0, dbg_ack}, 64'd0);
        @(negedge clk);
        chk("R7", "rvalid while pending", {63'd0, dbg_rvalid}, 64'd0);
        insn_uses_b = 1'b0;
        #1 chk("R7", "pending request accepted", {63'd0, dbg_ack}, 64'd1);
        @(negedge clk);
        chk("R8", "rvalid after read", {63'd0, dbg_rvalid}, 64'd1);
        chk("R8", "dbg_rdata entry 40", dbg_rdata, WC);
        dbg_req = 1'b0; insn_valid = 1'b1; insn_uses_b = 1'b1;

        // R6: during a stall the held instruction's B need applies
        @(negedge clk);
        stall = 1'b1; insn_valid = 1'b0;
        dbg_req = 1'b1; dbg_addr = 6'd9;
        #1 chk("R6", "ack during stall of B user", {63'd0, dbg_ack}, 64'd0);
        @(negedge clk);
        stall = 1'b0;
        #1 chk("R7", "ack after stall ends", {63'd0, dbg_ack}, 64'd1);
        @(negedge clk);
        chk("R8", "dbg_rdata entry 9", dbg_rdata, WD);
        dbg_req = 1'b0;

        // R9: debug write waits for the write port
        @(negedge clk);
        dbg_req = 1'b1; dbg_we = 1'b1; dbg_addr = 6'd12; dbg_wdata = WE;
        wr_en = 1'b1; wr_addr = 6'd13; wr_data = W5;
        #1 chk("R9", "debug write vs pipeline write", {63'd0, dbg_ack}, 64'd0);
        @(negedge clk);
        wr_en = 1'b0;
        #1 chk("R9", "debug write accepted", {63'd0, dbg_ack}, 64'd1);
        @(negedge clk);
        dbg_req = 1'b0; dbg_we = 1'b0;
        chk("R8", "no rvalid after write", {63'd0, dbg_rvalid}, 64'd0);
        rd_a_addr = 6'd12; rd_b_addr = 6'd12; rd_c_addr = 6'd13;
        @(negedge clk);
        chk("R9", "entry 12 holds debug data", rd_a_data, WE);
        chk("R4", "entry 13 holds pipeline data", rd_c_data, W5);

        // R8: debug read forwards a same-cycle pipeline write
        dbg_req = 1'b1; dbg_we = 1'b0; dbg_addr = 6'd20;
        wr_en = 1'b1; wr_addr = 6'd20; wr_data = W7;
        #1 chk("R9", "debug read not held by write", {63'd0, dbg_ack}, 64'd1);
        @(negedge clk);
        wr_en = 1'b0; dbg_req = 1'b0;
        chk("R8", "forwarded debug read valid", {63'd0, dbg_rvalid}, 64'd1);
        chk("R8", "forwarded debug read data", dbg_rdata, W7);

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule